// File: doc/BRIEF.md
# ADC Result Buffer Manager

This block sits between an ADC conversion sequencer and the software-visible result memory. Each time the sequencer presents a 10-bit result with a valid strobe, the block reformats the code into one of four 16-bit numeric formats. It then writes the word into a 16-word memory. Software selects the format, the buffer organisation and how many conversions make up one batch. It reads the stored words back through a simple synchronous read port.

The memory is used either as one 16-word buffer or as two 8-word halves. In split operation the halves are filled in one of two ways. In sequential fill, one half takes a whole batch and the next batch goes to the other half. In alternating fill, consecutive results go to alternate halves. A 4-bit sample-count setting N raises a one-cycle interrupt after N+1 accepted results, and the write position then returns to the start of its buffer. A sticky done flag shows that at least one result has landed. A half-indicator shows which half the next result will go to, so software can drain the other half. Clearing the enable input rearms the block.

Top module: `adc_resbuf`

## Requirements
- R1: After reset, `done`, `irq` and `fill_upper` are low.
- R2: With `split_mode` low, the k-th accepted result since the buffer start (k = 0..15) is written to word k.
- R3: With `split_mode` high and `alt_mode` low, the k-th result of a batch goes to slot k mod 8 of the active half: words 0-7 for the lower half, words 8-15 for the upper half. The active half starts as the lower one after enable and flips at every interrupt.
- R4: With `split_mode` and `alt_mode` high, result k of a batch goes to word (k mod 2)*8 + floor(k/2). Even results land in the lower half and odd results in the upper half.
- R5: With `fmt` = 0, the stored word is the raw code zero-extended to 16 bits.
- R6: With `fmt` = 1, the stored word is (raw - 512) as a 16-bit two's-complement value.
- R7: With `fmt` = 2, the stored word is the raw code shifted left by 6, with the low 6 bits zero. With `fmt` = 3, it is (raw - 512) shifted left by 6, in two's complement.
- R8: `irq` is high for exactly the one cycle after the clock edge that accepts the (`smpi`+1)-th result of a batch. With `smpi` = 0 it follows every result.
- R9: The result accepted after an interrupt is written at the buffer start: word 0 in single and alternating fill, slot 0 of the newly active half in sequential fill.
- R10: `done` rises in the cycle after the first accepted result and stays high while `en` stays high.
- R11: `fill_upper` is high exactly when the next result will be written into words 8-15 in split operation. It is always low when `split_mode` is low.
- R12: While `en` is low, results are ignored and memory is unchanged. After one edge with `en` low, the batch count, the write position, the active half, `done` and `fill_upper` are all cleared.
- R13: `rd_data` shows the word addressed by `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low rearms the block |
| split_mode | input | 1 | 1 = two 8-word halves, 0 = one 16-word buffer |
| alt_mode | input | 1 | In split operation, 1 = alternate halves per result |
| fmt | input | 2 | Result format: 0 uint, 1 signed, 2 fraction, 3 signed fraction |
| smpi | input | 4 | Results per interrupt minus one |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 10 | Raw conversion code |
| rd_addr | input | 4 | Software read address |
| rd_data | output | 16 | Registered read data |
| done | output | 1 | Result-available flag |
| fill_upper | output | 1 | Next result targets words 8-15 |
| irq | output | 1 | Batch-complete interrupt pulse |

## Verification
Stimulus is drawn from a fixed-seed random stream, mixed with directed runs of the end codes 0, 511, 512 and 1023. These codes separate an offset-by-half-scale error from a plain sign error in the signed formats, and a missing left-justify in the fractional ones. Each fill pattern (single, sequential halves, alternating halves) is run with batch sizes below, equal to and above eight. This shows whether the slot index wraps within a half or spills into the other half, and whether the pointer returns to the start on the interrupt. Disabling mid-batch and then re-enabling shows whether the counters and the active half restart, and whether the memory is left untouched.

// File: rtl/adc_resbuf_pkg.sv
package adc_resbuf_pkg;
  typedef enum logic [1:0] {
    FMT_UINT  = 2'd0,
    FMT_SINT  = 2'd1,
    FMT_UFRAC = 2'd2,
    FMT_SFRAC = 2'd3
  } res_fmt_e;
endpackage

// File: rtl/adc_resbuf_fmt.sv
module adc_resbuf_fmt
  import adc_resbuf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int OUT_W  = 16
) (
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] raw,
  output logic [OUT_W-1:0]  word
);
  localparam int PAD = OUT_W - DATA_W;

  logic [DATA_W-1:0] offs;  // raw minus half scale, two's complement
  res_fmt_e          sel;

  assign offs = {~raw[DATA_W-1], raw[DATA_W-2:0]};
  assign sel  = res_fmt_e'(fmt);

  always_comb begin
    unique case (sel)
      FMT_UINT:  word = {{PAD{1'b0}}, raw};
      FMT_SINT:  word = {{PAD{offs[DATA_W-1]}}, offs};
      FMT_UFRAC: word = {raw, {PAD{1'b0}}};
      default:   word = {offs, {PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/adc_resbuf_ctl.sv
module adc_resbuf_ctl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          split_mode,
  input  logic          alt_mode,
  input  logic [AW-1:0] smpi,
  input  logic          res_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic          fill_upper,
  output logic          irq
);
  logic [AW-1:0] cnt_q;
  logic          half_q;
  logic          last;

  assign wr_en = en & res_valid;
  assign last  = (cnt_q == smpi);

  always_comb begin
    if (!split_mode)    wr_addr = cnt_q;
    else if (alt_mode)  wr_addr = {cnt_q[0], cnt_q[AW-1:1]};
    else                wr_addr = {half_q, cnt_q[AW-2:0]};
  end

  assign fill_upper = split_mode & (alt_mode ? cnt_q[0] : half_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= wr_en & last;
      if (wr_en) begin
        done <= 1'b1;
        if (last) begin
          cnt_q <= '0;
          if (split_mode && !alt_mode) half_q <= ~half_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  irq_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en && res_valid));

  // R9
  ptr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt_q == '0));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> !$past(en));

  // R3
  half_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (half_q != $past(half_q)) |-> (irq || !$past(en)));

  // R12
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!done && !irq && cnt_q == '0));
endmodule

// File: rtl/adc_resbuf_mem.sv
module adc_resbuf_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/adc_resbuf.sv
module adc_resbuf #(
  parameter int DATA_W = 10,
  parameter int OUT_W  = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              split_mode,
  input  logic              alt_mode,
  input  logic [1:0]        fmt,
  input  logic [AW-1:0]     smpi,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [OUT_W-1:0]  rd_data,
  output logic              done,
  output logic              fill_upper,
  output logic              irq
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [OUT_W-1:0] wr_word;

  adc_resbuf_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst(rst), .en(en),
    .split_mode(split_mode), .alt_mode(alt_mode), .smpi(smpi),
    .res_valid(res_valid),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .done(done), .fill_upper(fill_upper), .irq(irq)
  );

  adc_resbuf_fmt #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_fmt (
    .fmt(fmt), .raw(res_data), .word(wr_word)
  );

  adc_resbuf_mem #(.DEPTH(DEPTH), .WIDTH(OUT_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_word),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R11
  upper_only_split_chk: assert property (@(posedge clk) disable iff (rst)
    fill_upper |-> split_mode);
endmodule

// File: tb/adc_resbuf_tb.sv
module adc_resbuf_tb;
  logic clk = 1'b0;
  logic rst, en, split_mode, alt_mode, res_valid;
  logic [1:0]  fmt;
  logic [3:0]  smpi, rd_addr;
  logic [9:0]  res_data;
  logic [15:0] rd_data;
  logic done, fill_upper, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [15:0] mem_m [16];
  bit          wr_m  [16];
  logic [3:0]  k_m;
  logic        half_m;

  always #4 clk = ~clk;

  adc_resbuf u_dut (
    .clk(clk), .rst(rst), .en(en), .split_mode(split_mode),
    .alt_mode(alt_mode), .fmt(fmt), .smpi(smpi), .res_valid(res_valid),
    .res_data(res_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .fill_upper(fill_upper), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [1:0] f, input logic [9:0] d);
    int v;
    v = int'(d) - 512;
    case (f)
      2'd0:    return {6'd0, d};
      2'd1:    return 16'(v);
      2'd2:    return 16'(int'(d) * 64);
      default: return 16'(v * 64);
    endcase
  endfunction

  function automatic logic [3:0] expect_addr();
    if (!split_mode) return k_m;
    if (alt_mode)    return {k_m[0], k_m[3:1]};
    return {half_m, k_m[2:0]};
  endfunction

  // Rearm: one edge with en low, new configuration, check cleared outputs (R12)
  task automatic restart(input bit sp, input bit al, input logic [1:0] f, input logic [3:0] n);
    @(negedge clk);
    en = 1'b0; split_mode = sp; alt_mode = al; fmt = f; smpi = n;
    @(negedge clk);
    check(!done && !irq && !fill_upper, "R12 cleared", {done, irq, fill_upper}, 0);
    en = 1'b1;
    k_m = '0; half_m = 1'b0;
  endtask

  task automatic send(input logic [9:0] d);
    logic [3:0] a;
    bit exp_irq;
    @(negedge clk);
    res_valid = 1'b1; res_data = d;
    a = expect_addr();
    @(negedge clk);
    res_valid = 1'b0;
    mem_m[a] = expect_word(fmt, d);
    wr_m[a]  = 1'b1;
    exp_irq  = (k_m == smpi);
    if (exp_irq) begin
      k_m = '0;
      if (split_mode && !alt_mode) half_m = ~half_m;
    end else begin
      k_m = k_m + 1'b1;
    end
    check(irq == exp_irq, "R8 irq", irq, exp_irq);
    check(done == 1'b1, "R10 done", done, 1);
    check(fill_upper == (split_mode && (alt_mode ? k_m[0] : half_m)), "R11 fill_upper",
          fill_upper, split_mode && (alt_mode ? k_m[0] : half_m));
    @(negedge clk);
    check(irq == 1'b0, "R8 pulse width", irq, 0);
  endtask

  task automatic readback(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_addr = 4'(i);
      @(negedge clk);
      if (wr_m[i]) check(rd_data == mem_m[i], req, rd_data, mem_m[i]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    rst = 1'b1; en = 1'b0; split_mode = 1'b0; alt_mode = 1'b0; fmt = 2'd0;
    smpi = 4'd0; res_valid = 1'b0; res_data = '0; rd_addr = '0;
    k_m = '0; half_m = 1'b0;
    for (int i = 0; i < 16; i++) wr_m[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !irq && !fill_upper, "R1 reset", {done, irq, fill_upper}, 0);
    rst = 1'b0;

    // R2 / R5 / R9: single buffer, full 16-word batch, unsigned
    restart(1'b0, 1'b0, 2'd0, 4'd15);
    for (int i = 0; i < 16; i++) send(10'(i * 61 + 3));
    readback("R2 R5 single uint");
    send(10'd1023);
    readback("R9 rewind single");

    // R6 / R13: end codes, signed integer, interrupt every sample
    restart(1'b0, 1'b0, 2'd1, 4'd0);
    send(10'd0); send(10'd511); send(10'd512); send(10'd1023);
    readback("R6 R13 signed");

    // R7: fractional formats
    restart(1'b0, 1'b0, 2'd2, 4'd3);
    send(10'd1023); send(10'd1); send(10'd512); send(10'd300);
    readback("R7 ufrac");
    restart(1'b0, 1'b0, 2'd3, 4'd3);
    send(10'd0); send(10'd1023); send(10'd512); send(10'd511);
    readback("R7 sfrac");

    // R3: sequential halves, batch of 8 then batch of 10 (wraps in half)
    restart(1'b1, 1'b0, 2'd0, 4'd7);
    for (int i = 0; i < 20; i++) send(10'($urandom));
    readback("R3 seq 8");
    restart(1'b1, 1'b0, 2'd1, 4'd9);
    for (int i = 0; i < 25; i++) send(10'($urandom));
    readback("R3 seq 10");

    // R4: alternating halves
    restart(1'b1, 1'b1, 2'd3, 4'd5);
    for (int i = 0; i < 14; i++) send(10'($urandom));
    readback("R4 alt 6");
    restart(1'b1, 1'b1, 2'd0, 4'd15);
    for (int i = 0; i < 16; i++) send(10'($urandom));
    readback("R4 alt 16");

    // R12: results while disabled are ignored
    @(negedge clk);
    en = 1'b0;
    res_valid = 1'b1; res_data = 10'h2aa;
    repeat (3) @(negedge clk);
    check(!done && !irq && !fill_upper, "R12 ignored flags", {done, irq, fill_upper}, 0);
    res_valid = 1'b0;
    readback("R12 memory unchanged");

    // Random configurations
    for (int r = 0; r < 40; r++) begin
      restart(1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom));
      for (int i = 0; i < 1 + ($urandom % 20); i++) send(10'($urandom));
      readback("R2 R3 R4 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule